// File: doc/BRIEF.md
# Serial EEPROM Command Front End

This block is the slave side of a four-wire serial link (SPI mode 0) for a byte-wide nonvolatile array. It shifts in an 8-bit command and recognises six commands: write-latch set, write-latch clear, status read, status write, array read and array write. It holds an 8-bit status byte. That byte carries a hardware-protect enable, two region-protect bits, the write-enable latch and a busy flag. For array commands it gathers a multi-byte address and drives a single-cycle synchronous byte port toward an external storage array. During reads it returns bytes on the serial output.

All serial inputs are resynchronised into the system clock domain, and edges of the serial clock are detected there. The serial clock must therefore be several times slower than the system clock. Programming time is modelled as a busy window of `BUSY_CYC` system clock cycles.

Top module: `eep_spi_ctrl`

## Requirements
- R1: A command is the first 8 bits after chip select falls, taken most significant bit first. Bits 7..4 must be 0000 and bit 3 is ignored. Bits 2..0 select the command: 110 sets the latch, 100 clears the latch, 101 reads status, 001 writes status, 011 reads the array and 010 writes the array.
- R2: After reset the status byte reads 0x00 and the serial output is not driven.
- R3: The latch-set command sets status bit 1. The latch-clear command clears it whatever the level of `wp_n`. Both take effect once the eighth command bit has been received.
- R4: Array writes and status writes change nothing unless status bit 1 is set when their command byte completes.
- R5: The status byte is laid out as bit 7 hardware-protect enable, bits 6..4 read as 0, bits 3..2 region protect, bit 1 write latch and bit 0 busy. A status write loads only bits 7, 3 and 2, and only when the chip select rises after the data byte. It is refused while bit 7 is 1 and `wp_n` is low.
- R6: An array read takes (ADDR_W+7)/8 address bytes, most significant first, and uses only their low ADDR_W bits. It then returns a byte on every following byte slot, with the address incrementing and wrapping from 2^ADDR_W-1 to 0. Each output bit changes after a falling serial clock edge.
- R7: An array write stores each data byte at an incrementing, wrapping address. A byte whose address lies in the protected region is dropped. The region is coded in status bits 3..2: 00 nothing, 01 the top quarter, 10 the top half, 11 the whole array.
- R8: When the chip select rises after a status write, or after an array write that stored at least one byte, status bit 0 is set for BUSY_CYC cycles. At the end of that window bits 0 and 1 both clear.
- R9: While busy, every command except status read is ignored. An array read drives nothing and an array write stores nothing.
- R10: A command byte that matches none of the six codes is ignored: the output stays undriven and the status is unchanged.
- R11: While chip select is high the output is undriven. Raising chip select in the middle of a byte discards the partial bits, and the next command is framed afresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | Serial clock from the master |
| cs_n | input | 1 | Chip select, active low |
| si | input | 1 | Serial data in |
| wp_n | input | 1 | Write-protect pin, active low |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for `so` (1 = driven) |
| mem_addr | output | ADDR_W | Array byte address |
| mem_rd_en | output | 1 | Array read strobe; data is expected on `mem_rdata` one cycle later |
| mem_wr_en | output | 1 | Array write strobe |
| mem_wdata | output | 8 | Array write data |
| mem_rdata | input | 8 | Array read data |

## Verification
The hardest state to reach from the ports is the busy window with the write latch still set. Only in that state can a refused command be told apart from one that was merely gated by the latch. The stimulus completes a write and then, before the window ends, issues a status read, an array read and a second array write. Afterwards it reads the array back to show that the second write left nothing behind. The refused status write under hardware protect is reached the same way: protect is enabled first, then `wp_n` is pulled low while the latch is set.

// File: rtl/eep_pkg.sv
package eep_pkg;

    typedef enum logic [2:0] {
        CMD_SETWE,
        CMD_CLRWE,
        CMD_RDST,
        CMD_WRST,
        CMD_RDARR,
        CMD_WRARR,
        CMD_NONE
    } cmd_e;

    typedef enum logic [2:0] {
        PH_OPC,
        PH_ADDR,
        PH_WDATA,
        PH_RDATA,
        PH_STOUT,
        PH_STIN,
        PH_SKIP
    } phase_e;

    typedef struct packed {
        logic       hwp_en;
        logic [1:0] prot;
        logic       we_latch;
        logic       busy;
    } stat_t;

    // Upper nibble must be zero; bit 3 carries no meaning.
    function automatic cmd_e decode(input logic [7:0] op);
        cmd_e c;
        c = CMD_NONE;
        if (op[7:4] == 4'b0000) begin
            case (op[2:0])
                3'b110:  c = CMD_SETWE;
                3'b100:  c = CMD_CLRWE;
                3'b101:  c = CMD_RDST;
                3'b001:  c = CMD_WRST;
                3'b011:  c = CMD_RDARR;
                3'b010:  c = CMD_WRARR;
                default: c = CMD_NONE;
            endcase
        end
        return c;
    endfunction

    function automatic logic [7:0] stat_byte(input stat_t s);
        return {s.hwp_en, 3'b000, s.prot, s.we_latch, s.busy};
    endfunction

    // hi = two most significant address bits
    function automatic logic in_protect(input logic [1:0] prot, input logic [1:0] hi);
        logic r;
        case (prot)
            2'b00:   r = 1'b0;
            2'b01:   r = (hi == 2'b11);
            2'b10:   r = hi[1];
            default: r = 1'b1;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/eep_spi_shift.sv
module eep_spi_shift #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sck,
    input  logic       cs_n,
    input  logic       si,
    input  logic [7:0] tx_byte,
    output logic       sel,
    output logic       sel_end,
    output logic       byte_done,
    output logic [7:0] rx_byte,
    output logic       so_bit
);
    logic [SYNC_STAGES-1:0] sck_q, cs_q, si_q;
    logic sck_d, cs_d;
    logic sck_s, cs_s, si_s;
    logic rise, fall;
    logic [2:0] cnt;
    logic [6:0] shreg;

    generate
        if (SYNC_STAGES == 1) begin : g_sync1
            always_ff @(posedge clk) begin
                if (rst) begin
                    sck_q <= '0;
                    cs_q  <= '1;
                    si_q  <= '0;
                end else begin
                    sck_q <= sck;
                    cs_q  <= cs_n;
                    si_q  <= si;
                end
            end
        end else begin : g_syncn
            always_ff @(posedge clk) begin
                if (rst) begin
                    sck_q <= '0;
                    cs_q  <= '1;
                    si_q  <= '0;
                end else begin
                    sck_q <= {sck_q[SYNC_STAGES-2:0], sck};
                    cs_q  <= {cs_q[SYNC_STAGES-2:0], cs_n};
                    si_q  <= {si_q[SYNC_STAGES-2:0], si};
                end
            end
        end
    endgenerate

    assign sck_s = sck_q[SYNC_STAGES-1];
    assign cs_s  = cs_q[SYNC_STAGES-1];
    assign si_s  = si_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_d <= 1'b0;
            cs_d  <= 1'b1;
        end else begin
            sck_d <= sck_s;
            cs_d  <= cs_s;
        end
    end

    assign rise    = sck_s & ~sck_d & ~cs_s;
    assign fall    = ~sck_s & sck_d & ~cs_s;
    assign sel     = ~cs_s;
    assign sel_end = cs_s & ~cs_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt       <= '0;
            shreg     <= '0;
            rx_byte   <= '0;
            byte_done <= 1'b0;
            so_bit    <= 1'b0;
        end else if (cs_s) begin
            cnt       <= '0;
            byte_done <= 1'b0;
        end else begin
            byte_done <= 1'b0;
            if (rise) begin
                shreg <= {shreg[5:0], si_s};
                cnt   <= cnt + 3'd1;
                if (cnt == 3'd7) begin
                    byte_done <= 1'b1;
                    rx_byte   <= {shreg, si_s};
                end
            end
            if (fall) begin
                so_bit <= tx_byte[3'd7 - cnt];
            end
        end
    end
endmodule

// File: rtl/eep_status.sv
module eep_status
    import eep_pkg::*;
#(
    parameter int BUSY_CYC = 2000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       set_we,
    input  logic       clr_we,
    input  logic       prog_go,
    input  logic       wr_stat,
    input  logic [7:0] wr_val,
    output stat_t      st
);
    localparam int TW = $clog2(BUSY_CYC + 1);
    logic [TW-1:0] tmr;

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= '0;
            tmr <= '0;
        end else begin
            if (wr_stat) begin
                st.hwp_en <= wr_val[7];
                st.prot   <= wr_val[3:2];
            end
            if (prog_go) begin
                st.busy <= 1'b1;
                tmr     <= TW'(BUSY_CYC - 1);
            end else if (st.busy) begin
                if (tmr == '0) begin
                    st.busy     <= 1'b0;
                    st.we_latch <= 1'b0;
                end else begin
                    tmr <= tmr - 1'b1;
                end
            end else if (set_we) begin
                st.we_latch <= 1'b1;
            end else if (clr_we) begin
                st.we_latch <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/eep_spi_ctrl.sv
module eep_spi_ctrl
    import eep_pkg::*;
#(
    parameter int ADDR_W      = 17,
    parameter int BUSY_CYC    = 2000,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sck,
    input  logic              cs_n,
    input  logic              si,
    input  logic              wp_n,
    output logic              so,
    output logic              so_oe,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd_en,
    output logic              mem_wr_en,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata
);
    localparam int ADDR_BYTES = (ADDR_W + 7) / 8;
    localparam int HOLD_W     = (ADDR_BYTES - 1) * 8;
    localparam int ACNT_W     = $clog2(ADDR_BYTES + 1);

    logic       sel, sel_end, byte_done, so_bit;
    logic [7:0] rx_byte;
    logic [7:0] tx;

    stat_t      st;
    logic       set_we, clr_we, prog_go, wr_stat;
    logic [7:0] st_val;
    logic       st_busy, st_wen;
    logic [1:0] st_prot;
    logic [7:0] st_byte;

    phase_e             ph;
    cmd_e               cmd;
    logic [HOLD_W-1:0]  hold;
    logic [HOLD_W+7:0]  full_addr;
    logic [ACNT_W-1:0]  acnt;
    logic [ADDR_W-1:0]  ptr;
    logic               rd_pend, prog_pend, st_pend;
    logic               wr_ok;

    eep_spi_shift #(.SYNC_STAGES(SYNC_STAGES)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .sck       (sck),
        .cs_n      (cs_n),
        .si        (si),
        .tx_byte   (tx),
        .sel       (sel),
        .sel_end   (sel_end),
        .byte_done (byte_done),
        .rx_byte   (rx_byte),
        .so_bit    (so_bit)
    );

    eep_status #(.BUSY_CYC(BUSY_CYC)) u_stat (
        .clk     (clk),
        .rst     (rst),
        .set_we  (set_we),
        .clr_we  (clr_we),
        .prog_go (prog_go),
        .wr_stat (wr_stat),
        .wr_val  (st_val),
        .st      (st)
    );

    assign st_busy   = st.busy;
    assign st_wen    = st.we_latch;
    assign st_prot   = st.prot;
    assign st_byte   = stat_byte(st);
    assign full_addr = {hold, rx_byte};
    assign wr_ok     = st.we_latch & ~st.busy;
    assign so        = so_bit;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph        <= PH_OPC;
            cmd       <= CMD_NONE;
            hold      <= '0;
            acnt      <= '0;
            ptr       <= '0;
            tx        <= '0;
            rd_pend   <= 1'b0;
            prog_pend <= 1'b0;
            st_pend   <= 1'b0;
            st_val    <= '0;
            set_we    <= 1'b0;
            clr_we    <= 1'b0;
            prog_go   <= 1'b0;
            wr_stat   <= 1'b0;
            mem_addr  <= '0;
            mem_rd_en <= 1'b0;
            mem_wr_en <= 1'b0;
            mem_wdata <= '0;
            so_oe     <= 1'b0;
        end else begin
            mem_rd_en <= 1'b0;
            mem_wr_en <= 1'b0;
            set_we    <= 1'b0;
            clr_we    <= 1'b0;
            prog_go   <= 1'b0;
            wr_stat   <= 1'b0;
            rd_pend   <= mem_rd_en;
            so_oe     <= sel && (ph == PH_RDATA || ph == PH_STOUT);
            if (rd_pend) begin
                tx <= mem_rdata;
            end
            if (sel_end) begin
                ph        <= PH_OPC;
                prog_go   <= prog_pend;
                wr_stat   <= st_pend;
                prog_pend <= 1'b0;
                st_pend   <= 1'b0;
            end else if (byte_done) begin
                case (ph)
                    PH_OPC: begin
                        cmd  <= decode(rx_byte);
                        acnt <= '0;
                        ph   <= PH_SKIP;
                        case (decode(rx_byte))
                            CMD_SETWE: set_we <= ~st.busy;
                            CMD_CLRWE: clr_we <= ~st.busy;
                            CMD_RDST: begin
                                ph <= PH_STOUT;
                                tx <= st_byte;
                            end
                            CMD_WRST: begin
                                if (wr_ok && !(st.hwp_en && !wp_n)) ph <= PH_STIN;
                            end
                            CMD_RDARR: begin
                                if (!st.busy) ph <= PH_ADDR;
                            end
                            CMD_WRARR: begin
                                if (wr_ok) ph <= PH_ADDR;
                            end
                            default: ph <= PH_SKIP;
                        endcase
                    end
                    PH_ADDR: begin
                        hold <= HOLD_W'(full_addr);
                        acnt <= acnt + 1'b1;
                        if (acnt == ACNT_W'(ADDR_BYTES - 1)) begin
                            if (cmd == CMD_RDARR) begin
                                mem_addr  <= full_addr[ADDR_W-1:0];
                                mem_rd_en <= 1'b1;
                                ptr       <= full_addr[ADDR_W-1:0] + 1'b1;
                                ph        <= PH_RDATA;
                            end else begin
                                ptr <= full_addr[ADDR_W-1:0];
                                ph  <= PH_WDATA;
                            end
                        end
                    end
                    PH_RDATA: begin
                        mem_addr  <= ptr;
                        mem_rd_en <= 1'b1;
                        ptr       <= ptr + 1'b1;
                    end
                    PH_WDATA: begin
                        if (!in_protect(st.prot, ptr[ADDR_W-1 -: 2])) begin
                            mem_addr  <= ptr;
                            mem_wdata <= rx_byte;
                            mem_wr_en <= 1'b1;
                            prog_pend <= 1'b1;
                        end
                        ptr <= ptr + 1'b1;
                    end
                    PH_STOUT: tx <= st_byte;
                    PH_STIN: begin
                        st_val    <= rx_byte;
                        st_pend   <= 1'b1;
                        prog_pend <= 1'b1;
                        ph        <= PH_SKIP;
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/eep_spi_ctrl_chk.sv
module eep_spi_ctrl_chk #(
    parameter int ADDR_W = 17
) (
    input logic              clk,
    input logic              rst,
    input logic              cs_n,
    input logic              so_oe,
    input logic              mem_wr_en,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              st_busy,
    input logic              st_wen,
    input logic [1:0]        st_prot,
    input logic [7:0]        st_byte
);
    a_r2_reset_status: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (st_byte == 8'h00 && !so_oe));

    a_r4_write_needs_latch: assert property (@(posedge clk) disable iff (rst)
        mem_wr_en |-> st_wen);

    a_r7_no_protected_store: assert property (@(posedge clk) disable iff (rst)
        mem_wr_en |-> !eep_pkg::in_protect(st_prot, mem_addr[ADDR_W-1 -: 2]));

    a_r8_end_clears_latch: assert property (@(posedge clk) disable iff (rst)
        $fell(st_busy) |-> !st_wen);

    a_r9_no_store_while_busy: assert property (@(posedge clk) disable iff (rst)
        st_busy |-> !mem_wr_en);

    a_r11_quiet_when_deselected: assert property (@(posedge clk) disable iff (rst)
        (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !so_oe);
endmodule

bind eep_spi_ctrl eep_spi_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cs_n      (cs_n),
    .so_oe     (so_oe),
    .mem_wr_en (mem_wr_en),
    .mem_addr  (mem_addr),
    .st_busy   (st_busy),
    .st_wen    (st_wen),
    .st_prot   (st_prot),
    .st_byte   (st_byte)
);

// File: tb/eep_spi_ctrl_tb.sv
`timescale 1ns/1ps
module eep_spi_ctrl_tb;
    localparam int AW   = 17;
    localparam int SIZE = 1 << AW;
    localparam int BUSY = 3000;
    localparam int H    = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sck = 1'b0, cs_n = 1'b1, si = 1'b0, wp_n = 1'b1;
    logic so, so_oe, mem_rd_en, mem_wr_en;
    logic [AW-1:0] mem_addr;
    logic [7:0] mem_wdata;
    logic [7:0] mem_rdata = 8'hFF;

    int nchk = 0, nfail = 0;
    logic [7:0] arr   [int];
    logic [7:0] ref_m [int];
    logic [7:0] tx_q [16];
    logic [7:0] rx_q [16];
    bit         oe_all [16];
    bit m_wen = 0, m_busy = 0, m_hwp = 0;
    logic [1:0] m_prot = 2'b00;

    always #2 clk = ~clk;

    eep_spi_ctrl #(.ADDR_W(AW), .BUSY_CYC(BUSY)) u_dut (
        .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .si(si), .wp_n(wp_n),
        .so(so), .so_oe(so_oe), .mem_addr(mem_addr), .mem_rd_en(mem_rd_en),
        .mem_wr_en(mem_wr_en), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    always @(posedge clk) begin
        if (mem_wr_en) arr[int'(mem_addr)] = mem_wdata;
        if (mem_rd_en) mem_rdata <= arr.exists(int'(mem_addr)) ? arr[int'(mem_addr)] : 8'hFF;
    end

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        nchk++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    function automatic logic [7:0] rb3();
        return ($urandom % 2) ? 8'h08 : 8'h00;
    endfunction

    function automatic bit b_prot(input logic [1:0] p, input int a);
        case (p)
            2'd0: return 0;
            2'd1: return a >= (SIZE / 4) * 3;
            2'd2: return a >= SIZE / 2;
            default: return 1;
        endcase
    endfunction

    function automatic logic [7:0] ref_rd(input int a);
        return ref_m.exists(a) ? ref_m[a] : 8'hFF;
    endfunction

    function automatic logic [7:0] exp_st();
        return {m_hwp, 3'b000, m_prot, m_wen, m_busy};
    endfunction

    task automatic spi(input int n);
        @(negedge clk) cs_n = 1'b0;
        repeat (H) @(negedge clk);
        for (int b = 0; b < n; b++) begin
            oe_all[b] = 1;
            for (int i = 7; i >= 0; i--) begin
                si = tx_q[b][i];
                repeat (H) @(negedge clk);
                rx_q[b][i] = so;
                if (so_oe !== 1'b1) oe_all[b] = 0;
                sck = 1'b1;
                repeat (H) @(negedge clk);
                sck = 1'b0;
            end
        end
        repeat (H) @(negedge clk);
        cs_n = 1'b1;
        repeat (2 * H) @(negedge clk);
    endtask

    task automatic spi_bits(input int nb);
        @(negedge clk) cs_n = 1'b0;
        repeat (H) @(negedge clk);
        for (int i = 0; i < nb; i++) begin
            si = 1'b0;
            repeat (H) @(negedge clk);
            sck = 1'b1;
            repeat (H) @(negedge clk);
            sck = 1'b0;
        end
        repeat (H) @(negedge clk);
        cs_n = 1'b1;
        repeat (2 * H) @(negedge clk);
    endtask

    task automatic op1(input logic [7:0] op);
        tx_q[0] = op;
        spi(1);
    endtask

    task automatic wren();
        op1(8'h06 | rb3());
        if (!m_busy) m_wen = 1;
    endtask

    task automatic wrdi();
        op1(8'h04 | rb3());
        if (!m_busy) m_wen = 0;
    endtask

    task automatic rdsr_chk(input string req);
        tx_q[0] = 8'h05 | rb3();
        tx_q[1] = 8'h00;
        spi(2);
        chk(req, rx_q[1], exp_st());
        chk(req, oe_all[1], 1);
    endtask

    task automatic wrsr(input logic [7:0] v);
        tx_q[0] = 8'h01 | rb3();
        tx_q[1] = v;
        spi(2);
        if (m_wen && !m_busy && !(m_hwp && !wp_n)) begin
            m_hwp  = v[7];
            m_prot = v[3:2];
            m_busy = 1;
        end
    endtask

    task automatic put_addr(input int a);
        logic [23:0] a24;
        a24 = {7'($urandom), 17'(a)};
        tx_q[1] = a24[23:16];
        tx_q[2] = a24[15:8];
        tx_q[3] = a24[7:0];
    endtask

    task automatic write_mem(input int a, input int n);
        bit ok, any;
        int aa;
        tx_q[0] = 8'h02 | rb3();
        put_addr(a);
        ok = m_wen && !m_busy;
        any = 0;
        aa = a;
        for (int k = 0; k < n; k++) begin
            tx_q[4 + k] = 8'($urandom);
            if (ok && !b_prot(m_prot, aa)) begin
                ref_m[aa] = tx_q[4 + k];
                any = 1;
            end
            aa = (aa + 1) % SIZE;
        end
        spi(4 + n);
        if (any) m_busy = 1;
    endtask

    task automatic read_chk(input int a, input int n, input string req);
        int aa;
        tx_q[0] = 8'h03 | rb3();
        put_addr(a);
        for (int k = 0; k < n; k++) tx_q[4 + k] = 8'h00;
        spi(4 + n);
        aa = a;
        for (int k = 0; k < n; k++) begin
            if (m_busy) begin
                chk({req, " idle while busy"}, oe_all[4 + k], 0);
            end else begin
                chk(req, rx_q[4 + k], ref_rd(aa));
                chk({req, " drive"}, oe_all[4 + k], 1);
            end
            aa = (aa + 1) % SIZE;
        end
    endtask

    task automatic wait_ready();
        repeat (BUSY + 300) @(negedge clk);
        if (m_busy) begin
            m_busy = 0;
            m_wen  = 0;
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog: got timeout expected completion");
        report();
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);

        // R2: reset state
        chk("R2 so_oe", so_oe, 0);
        rdsr_chk("R2 status");

        // R4: nothing happens without the latch
        write_mem(32'h40, 3);
        chk("R4 no busy", m_busy, 0);
        rdsr_chk("R4 status after gated write");
        read_chk(32'h40, 3, "R4 array untouched");
        wrsr(8'h8C);
        rdsr_chk("R4 status write gated");

        // R3 / R1: latch set and clear, bit 3 both ways
        op1(8'h0E); m_wen = 1;
        rdsr_chk("R1 R3 set with bit3=1");
        op1(8'h04); m_wen = 0;
        rdsr_chk("R1 R3 clear with bit3=0");
        op1(8'h06); m_wen = 1;
        op1(8'h0C); m_wen = 0;
        rdsr_chk("R1 R3 clear with bit3=1");

        // R8 / R9: busy window
        wren();
        write_mem(32'h100, 4);
        rdsr_chk("R8 busy and latch during window");
        read_chk(32'h100, 2, "R9 read refused");
        write_mem(32'h300, 2);
        wait_ready();
        rdsr_chk("R8 window end clears bits");
        read_chk(32'h100, 4, "R7 stored bytes");
        read_chk(32'h300, 2, "R9 write refused");

        // R6: wrap at top of array, upper address bits ignored
        wren();
        write_mem(SIZE - 2, 4);
        wait_ready();
        read_chk(SIZE - 1, 3, "R6 wrap read");
        read_chk(0, 2, "R6 wrapped write");

        // R5 / R7: region protect top quarter, bits 6..4 and 1..0 ignored
        wren();
        wrsr(8'h77);
        wait_ready();
        rdsr_chk("R5 only bits 7,3,2 loaded");
        wren();
        write_mem(32'h17FFE, 4);
        wait_ready();
        read_chk(32'h17FFE, 4, "R7 quarter boundary");
        wren();
        wrsr(8'h08);
        wait_ready();
        wren();
        write_mem(32'h0FFFF, 2);
        wait_ready();
        read_chk(32'h0FFFF, 2, "R7 half boundary");

        // R7: all protected, latch survives since nothing stored
        wren();
        wrsr(8'h0C);
        wait_ready();
        wren();
        write_mem(32'h20, 2);
        rdsr_chk("R7 all protected no busy");
        read_chk(32'h20, 2, "R7 all protected");

        // R5 / R3: hardware protect
        wrsr(8'h80);
        wait_ready();
        rdsr_chk("R5 hw protect enabled");
        wp_n = 1'b0;
        wren();
        wrsr(8'h8C);
        rdsr_chk("R5 refused under wp_n low");
        wrdi();
        rdsr_chk("R3 clear with wp_n low");
        wp_n = 1'b1;
        wren();
        wrsr(8'h00);
        wait_ready();
        rdsr_chk("R5 released");

        // R10: unknown codes
        wren();
        tx_q[0] = 8'h07; tx_q[1] = 8'h00;
        spi(2);
        chk("R10 undriven 07", oe_all[1], 0);
        tx_q[0] = 8'h45; tx_q[1] = 8'h00;
        spi(2);
        chk("R10 undriven 45", oe_all[1], 0);
        rdsr_chk("R10 status unchanged");

        // R11: partial framing and deselected output
        spi_bits(3);
        rdsr_chk("R11 after 3-bit frame");
        spi_bits(5);
        rdsr_chk("R11 after 5-bit frame");
        chk("R11 so_oe deselected", so_oe, 0);
        wrdi();

        // random mix
        for (int it = 0; it < 10; it++) begin
            int a, n;
            if ($urandom % 3 == 0) begin
                wren();
                wrsr({6'b0, 2'($urandom)} << 2);
                wait_ready();
            end
            if ($urandom % 4 != 0) wren();
            a = int'($urandom % SIZE);
            n = 1 + int'($urandom % 4);
            write_mem(a, n);
            wait_ready();
            rdsr_chk("R8 random status");
            read_chk(a, n, "R6 R7 random readback");
        end

        report();
    end
endmodule